// File: doc/BRIEF.md
# Half-Cycle Quadrature Power Demodulator

This block turns a stream of signed samples of a single-tone eddy-current pickup signal into a power estimate of that tone. Each accepted sample is multiplied by matching sine and cosine reference values. The reference tables hold only half a period of the excitation tone, so every window of `HALF_LEN` accepted samples yields an in-phase sum, a quadrature sum, a scaled power value and, when enabled, a magnitude. New results therefore arrive every half period of the tone.

Windows run back to back. The window index advances only on cycles where the sample-valid input is high, so gaps in the sample stream stretch a window without losing or misplacing any sample. The arithmetic is pipelined with one operation per clock. Each result comes with a one-cycle valid pulse, and each result register holds its value until the next pulse.

Top module: `hcq_demod`

## Requirements
- R1: The reference value at index k (0 ≤ k < HALF_LEN) is trunc(A·sin(πk/HALF_LEN)) for the sine table and trunc(A·cos(πk/HALF_LEN)) for the cosine table, with A = 2^(REF_W-1)-1 and truncation toward zero.
- R2: A window is HALF_LEN consecutive accepted samples, where a sample is accepted only when `smp_vld` is high. Data presented while `smp_vld` is low has no effect on any result, and the next window starts with the very next accepted sample at index 0.
- R3: `i_sum` is the exact sum over a window of sample times sine reference, and `q_sum` is the same sum taken with the cosine reference. Both are two's complement of width SAMPLE_W+REF_W+log2(HALF_LEN), which holds a window of full-scale products without overflow.
- R4: `iq_vld` is a one-cycle pulse that is high right after the third rising edge, counting as the first the edge that captures the last sample of a window. Two pulses are at least HALF_LEN cycles apart.
- R5: `pwr` equals (i_sum² + q_sum²) shifted right by 2·log2(HALF_LEN). `pwr_vld` pulses two cycles after `iq_vld`.
- R6: With EN_MAG = 1, `mag` equals floor(sqrt(pwr)) and `mag_vld` pulses one cycle after `pwr_vld`, which is three cycles after `iq_vld`.
- R7: While `rst` is high at a rising edge, all valid outputs go low, all result outputs become zero and the window index returns to 0, so a partly filled window is discarded.
- R8: `i_sum`, `q_sum`, `pwr` and `mag` keep their values in every cycle in which their own valid is not pulsing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample on `smp` is accepted this cycle |
| smp | input | SAMPLE_W | Signed input sample |
| i_sum | output | ACC_W | In-phase (sine) correlation sum of the last window |
| q_sum | output | ACC_W | Quadrature (cosine) correlation sum of the last window |
| iq_vld | output | 1 | Pulse: new `i_sum`/`q_sum` |
| pwr | output | PWR_W | Scaled power of the last window |
| pwr_vld | output | 1 | Pulse: new `pwr` |
| mag | output | MAG_W | Integer square root of `pwr` |
| mag_vld | output | 1 | Pulse: new `mag` |

## Verification
The hardest case to reach is a window that closes on an accumulator close to full scale while the sample stream has gaps, followed at once by the next window, so that clearing the accumulator and counting the gaps must both line up with the pipeline. The stimulus holds the samples at the positive and negative extremes for whole windows and drives a sampled copy of the sine reference. It also inserts random idle cycles that carry random data, and applies a reset partway through a window. A bench model follows every accepted sample, so any result or timing error shows up in the window where it occurs.

// File: rtl/hcq_pkg.sv
package hcq_pkg;
  localparam real PI_R = 3.14159265358979323846;

  // Reference sample for index k of a half-period table of length n.
  function automatic int ref_sample(input int k, input int n, input int w, input bit use_cos);
    real amp;
    real ang;
    amp = real'((1 << (w - 1)) - 1);
    ang = PI_R * real'(k) / real'(n);
    return use_cos ? $rtoi(amp * $cos(ang)) : $rtoi(amp * $sin(ang));
  endfunction
endpackage

// File: rtl/hcq_ref_rom.sv
module hcq_ref_rom #(
  parameter int DEPTH = 512,
  parameter int REF_W = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic [AW-1:0]           addr,
  output logic signed [REF_W-1:0] sin_q,
  output logic signed [REF_W-1:0] cos_q
);
  logic signed [REF_W-1:0] sin_mem [DEPTH];
  logic signed [REF_W-1:0] cos_mem [DEPTH];

  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      sin_mem[k] = REF_W'(hcq_pkg::ref_sample(k, DEPTH, REF_W, 1'b0));
      cos_mem[k] = REF_W'(hcq_pkg::ref_sample(k, DEPTH, REF_W, 1'b1));
    end
  end

  // Registered read so the tables map to block RAM.
  always_ff @(posedge clk) begin
    if (en) begin
      sin_q <= sin_mem[addr];
      cos_q <= cos_mem[addr];
    end
  end
endmodule

// File: rtl/hcq_corr.sv
module hcq_corr #(
  parameter int SAMPLE_W = 14,
  parameter int REF_W    = 16,
  parameter int HALF_LEN = 512,
  localparam int AW      = $clog2(HALF_LEN),
  localparam int PROD_W  = SAMPLE_W + REF_W,
  localparam int ACC_W   = PROD_W + AW
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       smp_vld,
  input  logic signed [SAMPLE_W-1:0] smp,
  output logic signed [ACC_W-1:0]    i_sum,
  output logic signed [ACC_W-1:0]    q_sum,
  output logic                       iq_vld
);
  localparam logic [AW-1:0] LAST_IDX = AW'(HALF_LEN - 1);

  logic [AW-1:0]               idx;
  logic signed [REF_W-1:0]     rom_sin, rom_cos;
  logic                        s1_v, s1_first, s1_last;
  logic signed [SAMPLE_W-1:0]  s1_x;
  logic                        p_v, p_first, p_last;
  logic signed [PROD_W-1:0]    p_i, p_q;
  logic signed [ACC_W-1:0]     acc_i, acc_q, nxt_i, nxt_q;

  // Window index: advances only on accepted samples, wraps at the end.
  always_ff @(posedge clk) begin
    if (rst)          idx <= '0;
    else if (smp_vld) idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
  end

  hcq_ref_rom #(.DEPTH(HALF_LEN), .REF_W(REF_W)) u_rom (
    .clk(clk), .en(smp_vld), .addr(idx), .sin_q(rom_sin), .cos_q(rom_cos)
  );

  // Stage 1: capture sample aligned with the table read.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0; s1_first <= 1'b0; s1_last <= 1'b0; s1_x <= '0;
    end else begin
      s1_v <= smp_vld;
      if (smp_vld) begin
        s1_x     <= smp;
        s1_first <= (idx == '0);
        s1_last  <= (idx == LAST_IDX);
      end
    end
  end

  // Stage 2: products.
  always_ff @(posedge clk) begin
    if (rst) begin
      p_v <= 1'b0; p_first <= 1'b0; p_last <= 1'b0; p_i <= '0; p_q <= '0;
    end else begin
      p_v <= s1_v;
      if (s1_v) begin
        p_i     <= s1_x * rom_sin;
        p_q     <= s1_x * rom_cos;
        p_first <= s1_first;
        p_last  <= s1_last;
      end
    end
  end

  always_comb begin
    nxt_i = (p_first ? ACC_W'(0) : acc_i) + ACC_W'(p_i);
    nxt_q = (p_first ? ACC_W'(0) : acc_q) + ACC_W'(p_q);
  end

  // Stage 3: accumulate, publish on the last sample.
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_i <= '0; acc_q <= '0; i_sum <= '0; q_sum <= '0; iq_vld <= 1'b0;
    end else begin
      iq_vld <= p_v && p_last;
      if (p_v) begin
        acc_i <= nxt_i;
        acc_q <= nxt_q;
        if (p_last) begin
          i_sum <= nxt_i;
          q_sum <= nxt_q;
        end
      end
    end
  end
endmodule

// File: rtl/hcq_power.sv
module hcq_power #(
  parameter int ACC_W  = 39,
  parameter int SHIFT  = 18,
  parameter bit EN_MAG = 1'b1,
  localparam int SQ_W  = 2 * ACC_W,
  localparam int PWR_W = SQ_W + 1 - SHIFT,
  localparam int MAG_W = (PWR_W + 1) / 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [ACC_W-1:0] i_in,
  input  logic signed [ACC_W-1:0] q_in,
  input  logic                    in_vld,
  output logic [PWR_W-1:0]        pwr,
  output logic                    pwr_vld,
  output logic [MAG_W-1:0]        mag,
  output logic                    mag_vld
);
  logic signed [SQ_W-1:0] i_ext, q_ext;
  logic [SQ_W-1:0]        sq_i, sq_q;
  logic                   sq_v;
  logic [SQ_W:0]          sq_sum;

  assign i_ext  = SQ_W'(i_in);
  assign q_ext  = SQ_W'(q_in);
  assign sq_sum = {1'b0, sq_i} + {1'b0, sq_q};

  // Stage A: squares.
  always_ff @(posedge clk) begin
    if (rst) begin
      sq_i <= '0; sq_q <= '0; sq_v <= 1'b0;
    end else begin
      sq_v <= in_vld;
      if (in_vld) begin
        sq_i <= $unsigned(i_ext * i_ext);
        sq_q <= $unsigned(q_ext * q_ext);
      end
    end
  end

  // Stage B: sum and constant scale.
  always_ff @(posedge clk) begin
    if (rst) begin
      pwr <= '0; pwr_vld <= 1'b0;
    end else begin
      pwr_vld <= sq_v;
      if (sq_v) pwr <= PWR_W'(sq_sum >> SHIFT);
    end
  end

  generate
    if (EN_MAG) begin : g_mag
      function automatic logic [MAG_W-1:0] isqrt(input logic [2*MAG_W-1:0] v);
        logic [MAG_W-1:0]   res;
        logic [MAG_W-1:0]   trial;
        logic [2*MAG_W-1:0] tsq;
        res = '0;
        for (int b = MAG_W - 1; b >= 0; b--) begin
          trial = res | (MAG_W'(1) << b);
          tsq   = (2*MAG_W)'(trial) * (2*MAG_W)'(trial);
          if (tsq <= v) res = trial;
        end
        return res;
      endfunction

      // Stage C: root.
      always_ff @(posedge clk) begin
        if (rst) begin
          mag <= '0; mag_vld <= 1'b0;
        end else begin
          mag_vld <= pwr_vld;
          if (pwr_vld) mag <= isqrt((2*MAG_W)'(pwr));
        end
      end
    end else begin : g_nomag
      assign mag     = '0;
      assign mag_vld = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/hcq_demod.sv
module hcq_demod #(
  parameter int SAMPLE_W = 14,
  parameter int REF_W    = 16,
  parameter int HALF_LEN = 512,
  parameter bit EN_MAG   = 1'b1,
  localparam int AW      = $clog2(HALF_LEN),
  localparam int ACC_W   = SAMPLE_W + REF_W + AW,
  localparam int PWR_W   = 2 * ACC_W + 1 - 2 * AW,
  localparam int MAG_W   = (PWR_W + 1) / 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       smp_vld,
  input  logic signed [SAMPLE_W-1:0] smp,
  output logic signed [ACC_W-1:0]    i_sum,
  output logic signed [ACC_W-1:0]    q_sum,
  output logic                       iq_vld,
  output logic [PWR_W-1:0]           pwr,
  output logic                       pwr_vld,
  output logic [MAG_W-1:0]           mag,
  output logic                       mag_vld
);
  hcq_corr #(.SAMPLE_W(SAMPLE_W), .REF_W(REF_W), .HALF_LEN(HALF_LEN)) u_corr (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp(smp),
    .i_sum(i_sum), .q_sum(q_sum), .iq_vld(iq_vld)
  );

  hcq_power #(.ACC_W(ACC_W), .SHIFT(2 * AW), .EN_MAG(EN_MAG)) u_pwr (
    .clk(clk), .rst(rst), .i_in(i_sum), .q_in(q_sum), .in_vld(iq_vld),
    .pwr(pwr), .pwr_vld(pwr_vld), .mag(mag), .mag_vld(mag_vld)
  );
endmodule

// File: rtl/hcq_demod_chk.sv
module hcq_demod_chk #(
  parameter int SAMPLE_W = 14,
  parameter int REF_W    = 16,
  parameter int HALF_LEN = 512,
  parameter bit EN_MAG   = 1'b1,
  localparam int AW      = $clog2(HALF_LEN),
  localparam int ACC_W   = SAMPLE_W + REF_W + AW,
  localparam int PWR_W   = 2 * ACC_W + 1 - 2 * AW,
  localparam int MAG_W   = (PWR_W + 1) / 2
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       smp_vld,
  input logic signed [SAMPLE_W-1:0] smp,
  input logic signed [ACC_W-1:0]    i_sum,
  input logic signed [ACC_W-1:0]    q_sum,
  input logic                       iq_vld,
  input logic [PWR_W-1:0]           pwr,
  input logic                       pwr_vld,
  input logic [MAG_W-1:0]           mag,
  input logic                       mag_vld
);
  localparam int GW = $clog2(HALF_LEN + 1) + 1;
  logic [GW-1:0] gap;
  logic          seen;
  logic [127:0]  m_sq, m1_sq, p_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap <= '0; seen <= 1'b0;
    end else if (iq_vld) begin
      gap <= GW'(1); seen <= 1'b1;
    end else if (gap < GW'(HALF_LEN)) begin
      gap <= gap + 1'b1;
    end
  end

  assign m_sq  = 128'(mag) * 128'(mag);
  assign m1_sq = (128'(mag) + 128'd1) * (128'(mag) + 128'd1);
  assign p_ext = 128'(pwr);

  assert_iq_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    iq_vld |=> !iq_vld);
  assert_iq_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    (iq_vld && seen) |-> (gap >= GW'(HALF_LEN)));
  assert_pwr_follows_R5: assert property (@(posedge clk) disable iff (rst)
    iq_vld |-> ##2 pwr_vld);
  assert_pwr_only_after_iq_R5: assert property (@(posedge clk) disable iff (rst)
    pwr_vld |-> $past(iq_vld, 2));
  assert_i_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !iq_vld |-> ($stable(i_sum) && $stable(q_sum)));
  assert_pwr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !pwr_vld |-> $stable(pwr));

  generate
    if (EN_MAG) begin : g_mag_chk
      assert_mag_follows_R6: assert property (@(posedge clk) disable iff (rst)
        pwr_vld |=> mag_vld);
      assert_mag_root_R6: assert property (@(posedge clk) disable iff (rst)
        mag_vld |-> (m_sq <= p_ext && m1_sq > p_ext));
    end
  endgenerate
endmodule

bind hcq_demod hcq_demod_chk #(
  .SAMPLE_W(SAMPLE_W), .REF_W(REF_W), .HALF_LEN(HALF_LEN), .EN_MAG(EN_MAG)
) u_chk (.*);

// File: tb/hcq_demod_test.sv
module hcq_demod_test;
  localparam int SW = 14;
  localparam int RW = 16;
  localparam int N  = 512;
  localparam int AW = $clog2(N);
  localparam int ACC_W = SW + RW + AW;
  localparam int PWR_W = 2 * ACC_W + 1 - 2 * AW;
  localparam int MAG_W = (PWR_W + 1) / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_vld = 1'b0;
  logic signed [SW-1:0] smp = '0;
  logic signed [ACC_W-1:0] i_sum, q_sum;
  logic iq_vld, pwr_vld, mag_vld;
  logic [PWR_W-1:0] pwr;
  logic [MAG_W-1:0] mag;

  always #5 clk = ~clk;

  hcq_demod uut (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp(smp),
    .i_sum(i_sum), .q_sum(q_sum), .iq_vld(iq_vld),
    .pwr(pwr), .pwr_vld(pwr_vld), .mag(mag), .mag_vld(mag_vld)
  );

  int n_tests = 0;
  int n_fail  = 0;
  longint ncnt = 0;
  bit done = 1'b0;

  always @(posedge clk) ncnt <= ncnt + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Bench model of the reference tables (R1).
  function automatic longint refv(input int k, input bit use_cos);
    real amp, ang;
    amp = 2.0 ** (RW - 1) - 1.0;
    ang = 3.14159265358979323846 * real'(k) / real'(N);
    return use_cos ? longint'($rtoi(amp * $cos(ang))) : longint'($rtoi(amp * $sin(ang)));
  endfunction

  function automatic logic [127:0] model_pwr(input longint iv, input longint qv);
    logic signed [127:0] a, b;
    a = 128'(iv);
    b = 128'(qv);
    return (a * a + b * b) >> (2 * AW);
  endfunction

  // Driver-side model state.
  int     idx = 0;
  longint acc_i = 0, acc_q = 0;
  longint q_ei[$], q_eq[$], q_et[$];
  logic [127:0] q_pw[$]; longint q_pt[$];
  longint q_mt[$];
  longint last_i = 0, last_q = 0;

  task automatic step(input bit v, input longint x);
    smp_vld = v;
    smp     = SW'(x);
    if (v) begin
      acc_i += x * refv(idx, 1'b0);
      acc_q += x * refv(idx, 1'b1);
      if (idx == N - 1) begin
        q_ei.push_back(acc_i); q_eq.push_back(acc_q); q_et.push_back(ncnt);
        acc_i = 0; acc_q = 0; idx = 0;
      end else idx++;
    end
    @(negedge clk);
  endtask

  // One window; gap_pct percent of cycles are idle with random data (R2).
  task automatic window(input int mode, input int gap_pct);
    int k;
    k = 0;
    while (k < N) begin
      if (gap_pct > 0 && ($urandom % 100) < gap_pct) begin
        step(1'b0, longint'($signed(SW'($urandom))));
      end else begin
        longint x;
        case (mode)
          0: x = 0;
          1: x = (1 <<< (SW - 1)) - 1;
          2: x = -(1 <<< (SW - 1));
          3: x = refv(k, 1'b0) >>> (RW - SW);
          4: x = (k % 2 == 0) ? -(1 <<< (SW - 1)) : (1 <<< (SW - 1)) - 1;
          default: x = longint'($signed(SW'($urandom)));
        endcase
        step(1'b1, x);
        k++;
      end
    end
  endtask

  // Monitor: values and cycle positions of every result (R3-R6).
  always @(negedge clk) begin
    if (!rst) begin
      if (iq_vld) begin
        if (q_ei.size() == 0) begin
          check(1'b0, "R4", "unexpected iq_vld", 1, 0);
        end else begin
          longint ei, eq, et;
          ei = q_ei.pop_front(); eq = q_eq.pop_front(); et = q_et.pop_front();
          check(longint'(i_sum) == ei, "R3", "i_sum", 128'(longint'(i_sum)), 128'(ei));
          check(longint'(q_sum) == eq, "R3", "q_sum", 128'(longint'(q_sum)), 128'(eq));
          check(ncnt == et + 3, "R4", "iq latency", 128'(ncnt - et), 3);
          q_pw.push_back(model_pwr(ei, eq)); q_pt.push_back(et);
          last_i = ei; last_q = eq;
        end
      end
      if (pwr_vld) begin
        if (q_pw.size() == 0) begin
          check(1'b0, "R5", "unexpected pwr_vld", 1, 0);
        end else begin
          logic [127:0] ep; longint pt;
          ep = q_pw.pop_front(); pt = q_pt.pop_front();
          check(128'(pwr) == ep, "R5", "pwr", 128'(pwr), ep);
          check(ncnt == pt + 5, "R5", "pwr latency", 128'(ncnt - pt), 5);
          q_mt.push_back(pt);
        end
      end
      if (mag_vld) begin
        if (q_mt.size() == 0) begin
          check(1'b0, "R6", "unexpected mag_vld", 1, 0);
        end else begin
          longint mt;
          logic [127:0] m, p;
          mt = q_mt.pop_front();
          m = 128'(mag); p = 128'(pwr);
          check(m * m <= p && (m + 1) * (m + 1) > p, "R6", "mag root", m, p);
          check(ncnt == mt + 6, "R6", "mag latency", 128'(ncnt - mt), 6);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7: reset state
    check(!iq_vld && !pwr_vld && !mag_vld, "R7", "valids after reset",
          {iq_vld, pwr_vld, mag_vld}, 0);
    check(i_sum == 0 && q_sum == 0 && pwr == 0 && mag == 0, "R7", "outputs after reset",
          128'(pwr), 0);

    window(0, 0);       // zero input
    window(1, 0);       // positive full scale, back to back (R3)
    window(2, 0);       // negative full scale (R3)
    window(3, 20);      // in-phase tone with gaps (R2)
    window(4, 0);       // alternating extremes
    window(5, 30);      // random with gaps (R2)
    window(5, 0);
    window(1, 40);      // full scale with many gaps

    // R7: reset partway through a window discards it
    for (int k = 0; k < 100; k++) step(1'b1, 4000);
    rst = 1'b1;
    idx = 0; acc_i = 0; acc_q = 0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    check(i_sum == 0 && q_sum == 0 && !iq_vld, "R7", "mid-window reset clears",
          128'(longint'(i_sum)), 0);
    window(5, 10);
    window(3, 0);

    smp_vld = 1'b0;
    repeat (20) @(negedge clk);
    check(q_ei.size() == 0 && q_pw.size() == 0 && q_mt.size() == 0, "R4",
          "all windows reported", 128'(q_ei.size()), 0);
    // R8: results held long after the last pulse
    check(longint'(i_sum) == last_i && longint'(q_sum) == last_q, "R8", "i/q hold",
          128'(longint'(i_sum)), 128'(last_i));
    check(128'(pwr) == model_pwr(last_i, last_q), "R8", "pwr hold",
          128'(pwr), model_pwr(last_i, last_q));
    finish_run();
  end
endmodule